// File: doc/BRIEF.md
# Winograd Tile Convolution with Fused Max-Pool

This block computes one pooled output value of a 3x3 convolution layer using the Winograd F(2x2,3x3) method. Each accepted step takes a 4x4 input feature-map tile and works against a 3x3 kernel loaded beforehand. The input tile goes through the B-transform and the kernel through the G-transform. The transformed 4x4 tiles are multiplied element by element, and the A-transform then yields a 2x2 block of convolution outputs. These four partial sums build up over a run of input channels.

When the tile flagged as the last input channel is accepted, the block finishes the output channel. It adds the bias held for that channel, shifts the sums right to the output exponent, saturates them to the output width and applies a Leaky ReLU with slope 1/8. A three-comparator max then reduces the four activated values to one word, which goes out on a valid/ready result port.

All data words are signed two's complement. A scheduler outside the block steps the tiles with stride 2, so neighbouring tiles share two rows or columns, and it chooses the per-layer shift.

Top module: `wgp_conv_pool`

## Requirements
- R1: While reset is asserted and directly after it, `r_valid_o` and `done_o` are 0 and both `t_ready_o` and `w_ready_o` are 1.
- R2: For a single input channel, the result equals max over the four positions (r,c) in {0,1}^2 of act(sat((sum_{i,j} tile[r+i][c+j]*kern[i][j] + bias) >>> shift_i)). Tile element (r,c) sits at bits [(r*4+c)*DW +: DW] of `tile_i`, and kernel element (i,j) sits at bits [(i*3+j)*KW +: KW] of `kern_i`.
- R3: Accepting a tile with `last_i`=0 adds its four convolution sums to the running sums and raises no result. Accepting a tile with `last_i`=1 raises `r_valid_o` after that same clock edge, with the sums of every tile since the previous result included.
- R4: The bias is taken from kernel loads made while no tile of the current output channel has been accepted. The `bias_i` value on kernel loads made after that has no effect on the result.
- R5: Before saturation, the sum is shifted right arithmetically by `shift_i` bits, rounding toward minus infinity.
- R6: The shifted value is clamped to the signed DW-bit range [-2^(DW-1), 2^(DW-1)-1].
- R7: A negative clamped value x becomes x >>> 3 (arithmetic, toward minus infinity), and a non-negative value passes unchanged.
- R8: The result is the largest of the four activated values, wherever in the 2x2 block that value lies.
- R9: While `r_valid_o`=1 and `r_ready_i`=0, `r_valid_o` and `r_data_o` hold and both ready outputs stay 0. The clock edge with `r_ready_i`=1 clears `r_valid_o`.
- R10: `done_o` is a one-cycle pulse in the first cycle of each result.
- R11: Once a result is produced, the running sums restart from zero for the next output channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_i | input | SHW | Right shift from the accumulator scale to the output exponent |
| w_valid_i | input | 1 | Kernel load request |
| w_ready_o | output | 1 | Kernel load accepted when high |
| kern_i | input | 9*KW | 3x3 kernel, element (i,j) at slot i*3+j |
| bias_i | input | BW | Output-channel bias at the accumulator scale |
| t_valid_i | input | 1 | Tile request |
| t_ready_o | output | 1 | Tile accepted when high |
| tile_i | input | 16*DW | 4x4 input tile, element (r,c) at slot r*4+c |
| last_i | input | 1 | Tile is the last input channel of this output |
| r_valid_o | output | 1 | Pooled result available |
| r_ready_i | input | 1 | Result taken |
| r_data_o | output | DW | Pooled, activated output word |
| done_o | output | 1 | Pulse in the first cycle of each result |

## Verification
The bench builds the block with its default widths: 8-bit data and kernel words, a 16-bit bias and a 32-bit accumulator. With 8-bit operands, full-scale tiles and kernels push the sums far past the output range, so both clamp bounds and the leaky branch can be driven directly. They also push the Winograd intermediates to their widest values, which tests the guard bits of the transform path. A 5-bit shift covers every exponent from an exact pass-through to shifts that reduce the sum to zero or to minus one.

// File: rtl/wgp_pkg.sv
package wgp_pkg;
  localparam int TI = 4;       // input tile edge
  localparam int TK = 3;       // kernel edge
  localparam int TO = 2;       // output tile edge
  localparam int NL = TO * TO; // output lanes
  localparam int LEAK_SH = 3;  // negative slope 1/8

  // entries of the 2x4 output transform
  function automatic int at_coef(input int o, input int i);
    if (o == 0) return (i < 3) ? 1 : 0;
    if (i == 0) return 0;
    return (i == 1) ? 1 : -1;
  endfunction
endpackage

// File: rtl/wgp_kern_xform.sv
// Kernel transform held at 4x scale (2G g 2G^T) so the halves stay exact.
module wgp_kern_xform
  import wgp_pkg::*;
#(
  parameter int KW = 8,
  parameter int UW = KW + 4
) (
  input  logic signed [KW-1:0] g_i [TK][TK],
  output logic signed [UW-1:0] u_o [TI][TI]
);
  logic signed [UW-1:0] t [TI][TK];

  always_comb begin
    for (int c = 0; c < TK; c++) begin
      t[0][c] = UW'(g_i[0][c]) + UW'(g_i[0][c]);
      t[1][c] = UW'(g_i[0][c]) + UW'(g_i[1][c]) + UW'(g_i[2][c]);
      t[2][c] = UW'(g_i[0][c]) - UW'(g_i[1][c]) + UW'(g_i[2][c]);
      t[3][c] = UW'(g_i[2][c]) + UW'(g_i[2][c]);
    end
    for (int r = 0; r < TI; r++) begin
      u_o[r][0] = t[r][0] + t[r][0];
      u_o[r][1] = t[r][0] + t[r][1] + t[r][2];
      u_o[r][2] = t[r][0] - t[r][1] + t[r][2];
      u_o[r][3] = t[r][2] + t[r][2];
    end
  end
endmodule

// File: rtl/wgp_in_xform.sv
module wgp_in_xform
  import wgp_pkg::*;
#(
  parameter int DW = 8,
  parameter int VW = DW + 2
) (
  input  logic signed [DW-1:0] d_i [TI][TI],
  output logic signed [VW-1:0] v_o [TI][TI]
);
  logic signed [VW-1:0] w [TI][TI];

  always_comb begin
    for (int c = 0; c < TI; c++) begin
      w[0][c] = VW'(d_i[0][c]) - VW'(d_i[2][c]);
      w[1][c] = VW'(d_i[1][c]) + VW'(d_i[2][c]);
      w[2][c] = VW'(d_i[2][c]) - VW'(d_i[1][c]);
      w[3][c] = VW'(d_i[1][c]) - VW'(d_i[3][c]);
    end
    for (int r = 0; r < TI; r++) begin
      v_o[r][0] = w[r][0] - w[r][2];
      v_o[r][1] = w[r][1] + w[r][2];
      v_o[r][2] = w[r][2] - w[r][1];
      v_o[r][3] = w[r][1] - w[r][3];
    end
  end
endmodule

// File: rtl/wgp_out_xform.sv
// Element products, then one adder-tree lane per output position.
module wgp_out_xform
  import wgp_pkg::*;
#(
  parameter int VW = 10,
  parameter int UW = 12,
  parameter int PW = VW + UW,
  parameter int YW = PW + 4
) (
  input  logic signed [VW-1:0] v_i [TI][TI],
  input  logic signed [UW-1:0] u_i [TI][TI],
  output logic signed [YW-1:0] y_o [NL]
);
  logic signed [PW-1:0] m [TI][TI];

  always_comb begin
    for (int i = 0; i < TI; i++)
      for (int j = 0; j < TI; j++)
        m[i][j] = PW'(v_i[i][j]) * PW'(u_i[i][j]);
  end

  for (genvar o = 0; o < NL; o++) begin : g_lane
    localparam int OR = o / TO;
    localparam int OC = o % TO;
    logic signed [YW-1:0] s;
    always_comb begin
      s = '0;
      for (int i = 0; i < TI; i++)
        for (int j = 0; j < TI; j++)
          case (at_coef(OR, i) * at_coef(OC, j))
            1:       s = s + YW'(m[i][j]);
            -1:      s = s - YW'(m[i][j]);
            default: ;
          endcase
    end
    // remove the 4x kernel scale; the sum is an exact multiple of 4
    assign y_o[o] = s >>> 2;
  end
endmodule

// File: rtl/wgp_act_pool.sv
module wgp_act_pool
  import wgp_pkg::*;
#(
  parameter int ACW = 32,
  parameter int DW  = 8,
  parameter int SHW = 5
) (
  input  logic signed [ACW-1:0] s_i [NL],
  input  logic        [SHW-1:0] shift_i,
  output logic signed [DW-1:0]  q_o
);
  localparam logic signed [ACW-1:0] SAT_HI = {{(ACW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACW-1:0] SAT_LO = ~SAT_HI;

  logic signed [ACW-1:0] r [NL];
  logic signed [DW-1:0]  c [NL];
  logic signed [DW-1:0]  a [NL];
  logic signed [DW-1:0]  m01, m23;

  always_comb begin
    for (int k = 0; k < NL; k++) begin
      r[k] = s_i[k] >>> shift_i;
      if (r[k] > SAT_HI)      c[k] = {1'b0, {(DW-1){1'b1}}};
      else if (r[k] < SAT_LO) c[k] = {1'b1, {(DW-1){1'b0}}};
      else                    c[k] = r[k][DW-1:0];
      a[k] = c[k][DW-1] ? (c[k] >>> LEAK_SH) : c[k];
    end
    m01 = (a[0] > a[1]) ? a[0] : a[1];
    m23 = (a[2] > a[3]) ? a[2] : a[3];
    q_o = (m01 > m23) ? m01 : m23;
  end
endmodule

// File: rtl/wgp_conv_pool.sv
module wgp_conv_pool
  import wgp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int KW  = 8,
  parameter int BW  = 16,
  parameter int ACW = 32,
  parameter int SHW = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SHW-1:0]        shift_i,
  input  logic                  w_valid_i,
  output logic                  w_ready_o,
  input  logic [TK*TK*KW-1:0]   kern_i,
  input  logic [BW-1:0]         bias_i,
  input  logic                  t_valid_i,
  output logic                  t_ready_o,
  input  logic [TI*TI*DW-1:0]   tile_i,
  input  logic                  last_i,
  output logic                  r_valid_o,
  input  logic                  r_ready_i,
  output logic [DW-1:0]         r_data_o,
  output logic                  done_o
);
  localparam int VW = DW + 2;
  localparam int UW = KW + 4;
  localparam int PW = VW + UW;
  localparam int YW = PW + 4;

  logic w_fire, t_fire, fresh_q;
  logic signed [KW-1:0]  g [TK][TK];
  logic signed [DW-1:0]  d [TI][TI];
  logic signed [UW-1:0]  u_new [TI][TI];
  logic signed [UW-1:0]  u_q [TI][TI];
  logic signed [VW-1:0]  v [TI][TI];
  logic signed [YW-1:0]  y [NL];
  logic signed [BW-1:0]  bias_q;
  logic signed [ACW-1:0] acc_q [NL];
  logic signed [ACW-1:0] acc_nxt [NL];
  logic signed [ACW-1:0] pre [NL];
  logic signed [DW-1:0]  q;

  assign w_ready_o = ~r_valid_o;
  assign t_ready_o = ~r_valid_o;
  assign w_fire    = w_valid_i & w_ready_o;
  assign t_fire    = t_valid_i & t_ready_o;

  always_comb begin
    for (int i = 0; i < TK; i++)
      for (int j = 0; j < TK; j++)
        g[i][j] = kern_i[(i*TK+j)*KW +: KW];
    for (int r = 0; r < TI; r++)
      for (int c = 0; c < TI; c++)
        d[r][c] = tile_i[(r*TI+c)*DW +: DW];
  end

  wgp_kern_xform #(.KW(KW), .UW(UW)) u_kx (.g_i(g), .u_o(u_new));
  wgp_in_xform   #(.DW(DW), .VW(VW)) u_ix (.d_i(d), .v_o(v));
  wgp_out_xform  #(.VW(VW), .UW(UW), .PW(PW), .YW(YW)) u_ox (
    .v_i(v), .u_i(u_q), .y_o(y)
  );

  always_comb begin
    for (int k = 0; k < NL; k++) begin
      acc_nxt[k] = acc_q[k] + ACW'(y[k]);
      pre[k]     = acc_nxt[k] + ACW'(bias_q);
    end
  end

  wgp_act_pool #(.ACW(ACW), .DW(DW), .SHW(SHW)) u_ap (
    .s_i(pre), .shift_i(shift_i), .q_o(q)
  );

  // transformed kernel is stored at load time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TI; i++)
        for (int j = 0; j < TI; j++)
          u_q[i][j] <= '0;
      bias_q <= '0;
    end else if (w_fire) begin
      u_q <= u_new;
      if (fresh_q) bias_q <= bias_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NL; k++) acc_q[k] <= '0;
      fresh_q   <= 1'b1;
      r_valid_o <= 1'b0;
      r_data_o  <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (r_valid_o && r_ready_i) r_valid_o <= 1'b0;
      if (t_fire) begin
        if (last_i) begin
          for (int k = 0; k < NL; k++) acc_q[k] <= '0;
          fresh_q   <= 1'b1;
          r_valid_o <= 1'b1;
          r_data_o  <= q;
          done_o    <= 1'b1;
        end else begin
          acc_q   <= acc_nxt;
          fresh_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wgp_conv_pool_chk.sv
module wgp_conv_pool_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          t_valid_i,
  input logic          t_ready_o,
  input logic          w_ready_o,
  input logic          last_i,
  input logic          r_valid_o,
  input logic          r_ready_i,
  input logic [DW-1:0] r_data_o,
  input logic          done_o
);
  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i |=> r_valid_o && $stable(r_data_o));
  // R9
  no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i |=> !t_ready_o && !w_ready_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(r_valid_o));
  // R3
  last_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_valid_i && t_ready_o && last_i |=> r_valid_o && done_o);
  // R3
  mid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_valid_i && t_ready_o && !last_i |=> !r_valid_o);
endmodule

bind wgp_conv_pool wgp_conv_pool_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .t_valid_i(t_valid_i), .t_ready_o(t_ready_o),
  .w_ready_o(w_ready_o), .last_i(last_i), .r_valid_o(r_valid_o),
  .r_ready_i(r_ready_i), .r_data_o(r_data_o), .done_o(done_o)
);

// File: tb/wgp_conv_pool_tb.sv
`timescale 1ns/1ps
module wgp_conv_pool_tb;
  localparam int DW = 8, KW = 8, BW = 16, ACW = 32, SHW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [SHW-1:0] shift_i = '0;
  logic w_valid_i = 1'b0, t_valid_i = 1'b0, last_i = 1'b0, r_ready_i = 1'b0;
  logic w_ready_o, t_ready_o, r_valid_o, done_o;
  logic [9*KW-1:0] kern_i = '0;
  logic [BW-1:0] bias_i = '0;
  logic [16*DW-1:0] tile_i = '0;
  logic [DW-1:0] r_data_o;

  always #10 clk = ~clk;

  wgp_conv_pool #(.DW(DW), .KW(KW), .BW(BW), .ACW(ACW), .SHW(SHW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .shift_i(shift_i), .w_valid_i(w_valid_i),
    .w_ready_o(w_ready_o), .kern_i(kern_i), .bias_i(bias_i), .t_valid_i(t_valid_i),
    .t_ready_o(t_ready_o), .tile_i(tile_i), .last_i(last_i), .r_valid_o(r_valid_o),
    .r_ready_i(r_ready_i), .r_data_o(r_data_o), .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0;
  int dmat [4][4];
  int gmat [3][3];
  longint eacc [4];
  longint ebias = 0;
  bit fresh_b = 1'b1;
  int unsigned seed = 32'd7;

  function automatic int unsigned prand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_rand(input int lim);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) dmat[r][c] = int'(prand() % (2*lim)) - lim;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) gmat[i][j] = int'(prand() % (2*lim)) - lim;
  endtask

  task automatic fill_const(input int dv, input int gv);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) dmat[r][c] = dv;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) gmat[i][j] = gv;
  endtask

  function automatic longint expect_out();
    longint best = -1000000;
    for (int k = 0; k < 4; k++) begin
      longint x = (eacc[k] + ebias) >>> shift_i;
      if (x > 127) x = 127;
      if (x < -128) x = -128;
      if (x < 0) x = x >>> 3;
      if (x > best) best = x;
    end
    return best;
  endfunction

  task automatic loadk(input int bias);
    @(negedge clk);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) kern_i[(i*3+j)*KW +: KW] = gmat[i][j][KW-1:0];
    bias_i = bias[BW-1:0];
    w_valid_i = 1'b1;
    @(posedge clk); #1;
    w_valid_i = 1'b0;
    if (fresh_b) ebias = bias;
  endtask

  task automatic feed(input bit last, input int hold, input string tag);
    longint ex;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 2; c++) begin
        longint s = 0;
        for (int i = 0; i < 3; i++)
          for (int j = 0; j < 3; j++) s += longint'(dmat[r+i][c+j]) * gmat[i][j];
        eacc[r*2+c] += s;
      end
    @(negedge clk);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) tile_i[(r*4+c)*DW +: DW] = dmat[r][c][DW-1:0];
    t_valid_i = 1'b1;
    last_i = last;
    @(posedge clk); #1;
    t_valid_i = 1'b0;
    last_i = 1'b0;
    fresh_b = last;
    if (!last) begin
      chk("R3 no result mid-run", r_valid_o, 0);
    end else begin
      ex = expect_out();
      chk({tag, " result"}, $signed(r_data_o), ex);
      chk("R3 valid after last", r_valid_o, 1);
      chk("R10 done pulse", done_o, 1);
      for (int h = 0; h < hold; h++) begin
        @(posedge clk); #1;
        chk("R9 valid held", r_valid_o, 1);
        chk("R9 data held", $signed(r_data_o), ex);
        chk("R9 tile ready low", t_ready_o, 0);
        chk("R9 weight ready low", w_ready_o, 0);
        chk("R10 done single", done_o, 0);
      end
      @(negedge clk);
      r_ready_i = 1'b1;
      @(posedge clk); #1;
      r_ready_i = 1'b0;
      chk("R9 released", r_valid_o, 0);
      chk("R10 done low", done_o, 0);
      for (int k = 0; k < 4; k++) eacc[k] = 0;
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) eacc[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", r_valid_o, 0);
    chk("R1 done in reset", done_o, 0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid", r_valid_o, 0);
    chk("R1 tile ready", t_ready_o, 1);
    chk("R1 weight ready", w_ready_o, 1);
  endtask

  task automatic t_basic();
    shift_i = 5'd4;
    for (int n = 0; n < 6; n++) begin
      fill_rand(16);
      loadk(int'(prand() % 400) - 200);
      feed(1'b1, 0, "R2");
    end
  endtask

  task automatic t_accum();
    shift_i = 5'd6;
    for (int ch = 0; ch < 4; ch++) begin
      fill_rand(64);
      loadk(int'(prand() % 400) - 200);
      feed(ch == 3, 0, "R3");
    end
  endtask

  task automatic t_bias_hold();
    shift_i = 5'd0;
    fill_rand(2);
    loadk(-20);
    feed(1'b0, 0, "R4");
    fill_rand(2);
    loadk(3000);  // not fresh: bias must be ignored
    feed(1'b1, 0, "R4");
  endtask

  task automatic t_shift();
    for (int s = 0; s < 6; s++) begin
      shift_i = 5'(s);
      fill_const(1, 1);
      loadk(7);
      feed(1'b1, 0, "R5");
      fill_const(1, -1);
      loadk(0);
      feed(1'b1, 0, "R5");
    end
  endtask

  task automatic t_sat();
    shift_i = 5'd0;
    fill_const(127, 127);
    loadk(0);
    feed(1'b1, 0, "R6");
    fill_const(127, -128);
    loadk(0);
    feed(1'b1, 0, "R6");
    fill_const(-128, -128);
    shift_i = 5'd10;
    loadk(0);
    feed(1'b1, 0, "R6");
  endtask

  task automatic t_leaky();
    shift_i = 5'd3;
    for (int n = 0; n < 3; n++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) dmat[r][c] = 1 + int'(prand() % 15);
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++) gmat[i][j] = -1 - int'(prand() % 15);
      loadk(0);
      feed(1'b1, 0, "R7");
    end
  endtask

  task automatic t_pool();
    shift_i = 5'd0;
    for (int p = 0; p < 4; p++) begin
      fill_const(0, 0);
      gmat[1][1] = 1;
      dmat[1 + p/2][1 + p%2] = 50;
      loadk(0);
      feed(1'b1, 0, "R8");
      fill_const(-40, 0);
      gmat[1][1] = 1;
      dmat[1 + p/2][1 + p%2] = -8;
      loadk(0);
      feed(1'b1, 0, "R8");
    end
  endtask

  task automatic t_back();
    shift_i = 5'd4;
    fill_rand(16);
    loadk(55);
    feed(1'b1, 3, "R9");
  endtask

  task automatic t_clear();
    shift_i = 5'd8;
    for (int ch = 0; ch < 3; ch++) begin
      fill_rand(120);
      loadk(1000);
      feed(ch == 2, 0, "R11");
    end
    shift_i = 5'd2;
    fill_rand(8);
    loadk(-5);
    feed(1'b1, 0, "R11");
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_basic();
    t_accum();
    t_bias_hold();
    t_shift();
    t_sat();
    t_leaky();
    t_pool();
    t_back();
    t_clear();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule